// File: doc/BRIEF.md
# Class-Routed Reservation Station Bank

This block holds instructions that have been issued in order but are waiting for their operands, in a core that schedules work out of order. Each cycle the issue stage may present one decoded instruction. The instruction carries a class code, a reorder-buffer tag, an operation word, and a fixed number of operands. Each operand is either a finished value or the tag of the result it is waiting for. The bank places the instruction in a station that belongs to its class and records which operands are still pending. It then watches the result broadcast bus and fills in those operands as matching tags appear.

The bank has eight stations. Four interchangeable integer stations feed the integer unit. The other four each belong to one unit: FP add/subtract, FP multiply/divide, the remaining FP operations (negate, absolute value, square root, remainder, moves, conversions, integer/FP transfers, compares), and memory. A station whose operands are all present is sent to its unit unless that unit is stalling. The integer unit gets its instruction from a rotating arbiter over the four integer stations. Dispatched contents leave through a registered port for each unit.

Top module: `rs_bank`

## Requirements
- R1: After synchronous reset every station is empty, `disp_valid_o` is all zero and `iss_stall_o` is low.
- R2: Class codes route as follows: 0 integer (stations 0..3, lowest free index first, dispatch port 0), 1 FP add/subtract (station 4, port 1), 2 FP multiply/divide (station 5, port 2), 3 other FP (station 6, port 3), 4 memory (station 7, port 4).
- R3: An accepted issue stores the ROB tag, the operation word and the operands. A later dispatch presents exactly these on the port, with operand k in bits [k*DW +: DW].
- R4: When `iss_rdy_i[k]` is low, the tag an operand waits for sits in bits [k*DW +: TW] of its field. A result bus broadcast (`cdb_valid_i` high) whose tag equals a pending operand's tag replaces that operand with `cdb_data_i` and marks it present.
- R5: If a broadcast happens in the same cycle as an issue and matches a pending operand of that issue, the operand is captured as present with the broadcast data.
- R6: `iss_stall_o` is high exactly when the incoming class is integer and all four integer stations are occupied, or when the class is 1..4 and its station is occupied. A stalled issue changes no station.
- R7: A station is dispatched at a clock edge only if, before that edge, it is occupied, all its operands are present and its unit's `unit_stall_i` bit is low. `disp_valid_o[u]` is high for that one following cycle only, and the station becomes free.
- R8: The integer grant goes to the first ready integer station at or after a rotating pointer. The pointer moves to one past the granted station only when `unit_stall_i[0]` is low and a grant is made; otherwise it holds.
- R9: Issues with class codes 5, 6 or 7 are ignored: no station is loaded and `iss_stall_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid_i | input | 1 | Issue request |
| iss_class_i | input | 3 | Instruction class code |
| iss_tag_i | input | TW | ROB tag of the issuing instruction |
| iss_opc_i | input | OPW | Operation word |
| iss_rdy_i | input | NOPS | Per-operand present flag |
| iss_ops_i | input | NOPS*DW | Operand values or waited-for tags |
| iss_stall_o | output | 1 | Target station(s) full; issue not accepted |
| cdb_valid_i | input | 1 | Result broadcast valid |
| cdb_tag_i | input | TW | Tag of broadcast result |
| cdb_data_i | input | DW | Broadcast result value |
| unit_stall_i | input | 5 | Per-unit stall, bit u for port u |
| disp_valid_o | output | 5 | Per-unit dispatch valid |
| disp_tag_o | output | 5*TW | Dispatched ROB tags |
| disp_opc_o | output | 5*OPW | Dispatched operation words |
| disp_ops_o | output | 5*NOPS*DW | Dispatched operand values |

## Verification
`iss_stall_o` is a combinational function of the current occupancy and the class being presented. The bench therefore checks it after driving the inputs and before the next rising edge. Operand readiness is registered, so a station loaded with all operands present dispatches at the second edge after its issue. An operand filled by a broadcast makes its station eligible at the edge after the fill. The dispatch port is registered and shows its result one edge after the station is chosen. The bench keeps a reference model of occupancy, operand state and the arbiter pointer. The model advances once per edge in the same order, and the ports are compared one time unit after each rising edge.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [2:0] {
    CLS_INT   = 3'd0,
    CLS_FADD  = 3'd1,
    CLS_FMUL  = 3'd2,
    CLS_FMISC = 3'd3,
    CLS_MEM   = 3'd4
  } rs_class_e;

  // stations dedicated to a single unit, one per non-integer class
  localparam int FIXED_RS  = 4;
  // integer unit plus one unit per fixed station
  localparam int NUM_UNITS = FIXED_RS + 1;
endpackage

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int DW   = 32,
  parameter int TW   = 4,
  parameter int OPW  = 8,
  parameter int NOPS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enq_i,
  input  logic [TW-1:0]        enq_tag_i,
  input  logic [OPW-1:0]       enq_opc_i,
  input  logic [NOPS-1:0]      enq_rdy_i,
  input  logic [NOPS*DW-1:0]   enq_ops_i,
  input  logic                 cdb_valid_i,
  input  logic [TW-1:0]        cdb_tag_i,
  input  logic [DW-1:0]        cdb_data_i,
  input  logic                 deq_i,
  output logic                 valid_o,
  output logic                 ready_o,
  output logic [TW-1:0]        tag_o,
  output logic [OPW-1:0]       opc_o,
  output logic [NOPS*DW-1:0]   ops_o
);
  logic               valid_q;
  logic [NOPS-1:0]    rdy_q;
  logic [NOPS*DW-1:0] val_q;
  logic [TW-1:0]      tag_q;
  logic [OPW-1:0]     opc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      rdy_q   <= '0;
    end else if (enq_i) begin
      valid_q <= 1'b1;
      for (int k = 0; k < NOPS; k++) begin
        if (enq_rdy_i[k]) begin
          rdy_q[k] <= 1'b1;
        end else if (cdb_valid_i && enq_ops_i[k*DW +: TW] == cdb_tag_i) begin
          rdy_q[k] <= 1'b1;
        end else begin
          rdy_q[k] <= 1'b0;
        end
      end
    end else begin
      if (deq_i) valid_q <= 1'b0;
      for (int k = 0; k < NOPS; k++) begin
        if (valid_q && !rdy_q[k] && cdb_valid_i && val_q[k*DW +: TW] == cdb_tag_i)
          rdy_q[k] <= 1'b1;
      end
    end
  end

  // payload registers carry no reset
  always_ff @(posedge clk) begin
    if (enq_i) begin
      tag_q <= enq_tag_i;
      opc_q <= enq_opc_i;
      for (int k = 0; k < NOPS; k++) begin
        if (!enq_rdy_i[k] && cdb_valid_i && enq_ops_i[k*DW +: TW] == cdb_tag_i)
          val_q[k*DW +: DW] <= cdb_data_i;
        else
          val_q[k*DW +: DW] <= enq_ops_i[k*DW +: DW];
      end
    end else begin
      for (int k = 0; k < NOPS; k++) begin
        if (valid_q && !rdy_q[k] && cdb_valid_i && val_q[k*DW +: TW] == cdb_tag_i)
          val_q[k*DW +: DW] <= cdb_data_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q && (&rdy_q);
  assign tag_o   = tag_q;
  assign opc_o   = opc_q;
  assign ops_o   = val_q;

  assert_enq_free_R6: assert property (@(posedge clk) disable iff (rst)
    enq_i |-> !valid_q);
  assert_deq_ready_R7: assert property (@(posedge clk) disable iff (rst)
    deq_i |-> ready_o);
  assert_deq_frees_R7: assert property (@(posedge clk) disable iff (rst)
    (deq_i && !enq_i) |=> !valid_q);

  for (genvar k = 0; k < NOPS; k++) begin : g_snoop_chk
    assert_snoop_fill_R4: assert property (@(posedge clk) disable iff (rst)
      (valid_q && !enq_i && !rdy_q[k] && cdb_valid_i && val_q[k*DW +: TW] == cdb_tag_i)
      |=> (rdy_q[k] && val_q[k*DW +: DW] == $past(cdb_data_i)));
  end
endmodule

// File: rtl/rs_rr_arb.sv
module rs_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] gidx;

  always_comb begin
    int idx;
    gnt_o = '0;
    any_o = 1'b0;
    gidx  = '0;
    for (int off = 0; off < N; off++) begin
      idx = (int'(ptr_q) + off) % N;
      if (!any_o && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        any_o      = 1'b1;
        gidx       = PW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (adv_i && any_o) begin
      ptr_q <= (int'(gidx) == N - 1) ? '0 : gidx + 1'b1;
    end
  end

  assert_gnt_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o));
  assert_gnt_has_req_R8: assert property (@(posedge clk) disable iff (rst)
    (gnt_o & ~req_i) == '0);
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(ptr_q));
endmodule

// File: rtl/rs_alloc.sv
module rs_alloc
  import rs_pkg::*;
#(
  parameter int NINT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                iss_valid_i,
  input  logic [2:0]          iss_class_i,
  input  logic [NINT-1:0]     int_valid_i,
  input  logic [FIXED_RS-1:0] fix_valid_i,
  output logic                stall_o,
  output logic [NINT-1:0]     int_enq_o,
  output logic [FIXED_RS-1:0] fix_enq_o
);
  logic [1:0] fidx;
  logic       found;

  assign fidx = 2'(iss_class_i - 3'd1);

  always_comb begin
    stall_o   = 1'b0;
    int_enq_o = '0;
    fix_enq_o = '0;
    found     = 1'b0;
    if (iss_class_i == CLS_INT) begin
      stall_o = &int_valid_i;
      if (iss_valid_i && !stall_o) begin
        for (int i = 0; i < NINT; i++) begin
          if (!found && !int_valid_i[i]) begin
            int_enq_o[i] = 1'b1;
            found        = 1'b1;
          end
        end
      end
    end else if (iss_class_i <= CLS_MEM) begin
      stall_o = fix_valid_i[fidx];
      if (iss_valid_i && !stall_o) fix_enq_o[fidx] = 1'b1;
    end
  end

  assert_one_target_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({int_enq_o, fix_enq_o}));
  assert_stall_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> ({int_enq_o, fix_enq_o} == '0));
  assert_reserved_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (iss_class_i > CLS_MEM) |-> (!stall_o && {int_enq_o, fix_enq_o} == '0));
endmodule

// File: rtl/rs_bank.sv
module rs_bank
  import rs_pkg::*;
#(
  parameter int DW   = 32,
  parameter int TW   = 4,
  parameter int OPW  = 8,
  parameter int NOPS = 2,
  parameter int NINT = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           iss_valid_i,
  input  logic [2:0]                     iss_class_i,
  input  logic [TW-1:0]                  iss_tag_i,
  input  logic [OPW-1:0]                 iss_opc_i,
  input  logic [NOPS-1:0]                iss_rdy_i,
  input  logic [NOPS*DW-1:0]             iss_ops_i,
  output logic                           iss_stall_o,
  input  logic                           cdb_valid_i,
  input  logic [TW-1:0]                  cdb_tag_i,
  input  logic [DW-1:0]                  cdb_data_i,
  input  logic [NUM_UNITS-1:0]           unit_stall_i,
  output logic [NUM_UNITS-1:0]           disp_valid_o,
  output logic [NUM_UNITS*TW-1:0]        disp_tag_o,
  output logic [NUM_UNITS*OPW-1:0]       disp_opc_o,
  output logic [NUM_UNITS*NOPS*DW-1:0]   disp_ops_o
);
  localparam int NRS = NINT + FIXED_RS;
  localparam int NU  = NUM_UNITS;
  localparam int SW  = $clog2(NRS);
  localparam int OW  = NOPS * DW;

  logic [NRS-1:0]  ent_valid, ent_ready, ent_enq, ent_deq;
  logic [TW-1:0]   ent_tag [NRS];
  logic [OPW-1:0]  ent_opc [NRS];
  logic [OW-1:0]   ent_ops [NRS];
  logic [NINT-1:0] int_gnt;
  logic            int_any;
  logic [NU-1:0]   sel_go;
  logic [SW-1:0]   sel_idx [NU];

  rs_alloc #(.NINT(NINT)) u_alloc (
    .clk         (clk),
    .rst         (rst),
    .iss_valid_i (iss_valid_i),
    .iss_class_i (iss_class_i),
    .int_valid_i (ent_valid[NINT-1:0]),
    .fix_valid_i (ent_valid[NRS-1:NINT]),
    .stall_o     (iss_stall_o),
    .int_enq_o   (ent_enq[NINT-1:0]),
    .fix_enq_o   (ent_enq[NRS-1:NINT])
  );

  rs_rr_arb #(.N(NINT)) u_int_arb (
    .clk   (clk),
    .rst   (rst),
    .req_i (ent_ready[NINT-1:0]),
    .adv_i (!unit_stall_i[0]),
    .gnt_o (int_gnt),
    .any_o (int_any)
  );

  assign ent_deq[NINT-1:0] = int_gnt & {NINT{!unit_stall_i[0]}};

  for (genvar f = 0; f < FIXED_RS; f++) begin : g_fix_deq
    assign ent_deq[NINT+f] = ent_ready[NINT+f] && !unit_stall_i[f+1];
  end

  for (genvar s = 0; s < NRS; s++) begin : g_station
    rs_entry #(.DW(DW), .TW(TW), .OPW(OPW), .NOPS(NOPS)) u_entry (
      .clk         (clk),
      .rst         (rst),
      .enq_i       (ent_enq[s]),
      .enq_tag_i   (iss_tag_i),
      .enq_opc_i   (iss_opc_i),
      .enq_rdy_i   (iss_rdy_i),
      .enq_ops_i   (iss_ops_i),
      .cdb_valid_i (cdb_valid_i),
      .cdb_tag_i   (cdb_tag_i),
      .cdb_data_i  (cdb_data_i),
      .deq_i       (ent_deq[s]),
      .valid_o     (ent_valid[s]),
      .ready_o     (ent_ready[s]),
      .tag_o       (ent_tag[s]),
      .opc_o       (ent_opc[s]),
      .ops_o       (ent_ops[s])
    );
  end

  // per-unit source station selection
  always_comb begin
    sel_go        = '0;
    sel_idx[0]    = '0;
    sel_go[0]     = int_any && !unit_stall_i[0];
    for (int i = 0; i < NINT; i++) begin
      if (int_gnt[i]) sel_idx[0] = SW'(i);
    end
    for (int u = 1; u < NU; u++) begin
      sel_go[u]  = ent_deq[NINT+u-1];
      sel_idx[u] = SW'(NINT + u - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) disp_valid_o <= '0;
    else     disp_valid_o <= sel_go;
  end

  always_ff @(posedge clk) begin
    for (int u = 0; u < NU; u++) begin
      if (sel_go[u]) begin
        disp_tag_o[u*TW +: TW]   <= ent_tag[sel_idx[u]];
        disp_opc_o[u*OPW +: OPW] <= ent_opc[sel_idx[u]];
        disp_ops_o[u*OW +: OW]   <= ent_ops[sel_idx[u]];
      end
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_unit_chk
    assert_stall_no_disp_R7: assert property (@(posedge clk) disable iff (rst)
      unit_stall_i[u] |=> !disp_valid_o[u]);
  end

  for (genvar f = 0; f < FIXED_RS; f++) begin : g_route_chk
    assert_route_R2: assert property (@(posedge clk) disable iff (rst)
      disp_valid_o[f+1] |-> $past(ent_ready[NINT+f]));
  end
endmodule

// File: tb/rs_bank_tb_top.sv
module rs_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, TW = 4, OPW = 8, NOPS = 2, NU = 5, NRS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 1'b0;
  logic [2:0] iss_class = '0;
  logic [TW-1:0] iss_tag = '0;
  logic [OPW-1:0] iss_opc = '0;
  logic [NOPS-1:0] iss_rdy = '0;
  logic [NOPS*DW-1:0] iss_ops = '0;
  logic iss_stall;
  logic cdb_valid = 1'b0;
  logic [TW-1:0] cdb_tag = '0;
  logic [DW-1:0] cdb_data = '0;
  logic [NU-1:0] unit_stall = '0;
  logic [NU-1:0] disp_valid;
  logic [NU*TW-1:0] disp_tag;
  logic [NU*OPW-1:0] disp_opc;
  logic [NU*NOPS*DW-1:0] disp_ops;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_bank dut_i (
    .clk(clk), .rst(rst),
    .iss_valid_i(iss_valid), .iss_class_i(iss_class), .iss_tag_i(iss_tag),
    .iss_opc_i(iss_opc), .iss_rdy_i(iss_rdy), .iss_ops_i(iss_ops),
    .iss_stall_o(iss_stall),
    .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_data_i(cdb_data),
    .unit_stall_i(unit_stall),
    .disp_valid_o(disp_valid), .disp_tag_o(disp_tag),
    .disp_opc_o(disp_opc), .disp_ops_o(disp_ops)
  );

  // reference model state
  bit          m_v   [NRS];
  logic [3:0]  m_tag [NRS];
  logic [7:0]  m_opc [NRS];
  bit          m_rdy [NRS][NOPS];
  logic [31:0] m_val [NRS][NOPS];
  int          m_ptr;
  bit          e_dv  [NU];
  logic [3:0]  e_tag [NU];
  logic [7:0]  e_opc [NU];
  logic [31:0] e_ops [NU][NOPS];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit model_stall(input int cls);
    if (cls == 0) return m_v[0] && m_v[1] && m_v[2] && m_v[3];
    if (cls >= 1 && cls <= 4) return m_v[cls+3];
    return 1'b0;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < NRS; s++) m_v[s] = 1'b0;
    m_ptr = 0;
  endtask

  task automatic load_disp(input int u, input int s);
    e_dv[u] = 1'b1;
    e_tag[u] = m_tag[s];
    e_opc[u] = m_opc[s];
    for (int k = 0; k < NOPS; k++) e_ops[u][k] = m_val[s][k];
    m_v[s] = 1'b0;
  endtask

  task automatic step(input bit iv, input int cls, input logic [3:0] tg,
                      input logic [7:0] opc, input bit r0, input bit r1,
                      input logic [31:0] v0, input logic [31:0] v1,
                      input bit cv, input logic [3:0] ct, input logic [31:0] cd,
                      input logic [4:0] stl);
    bit st;
    bit rdyv [NRS];
    int tgt;
    bit found;
    bit r [NOPS];
    logic [31:0] v [NOPS];
    iss_valid = iss_valid;
    iss_valid = iv; iss_class = 3'(cls); iss_tag = tg; iss_opc = opc;
    iss_rdy = {r1, r0}; iss_ops = {v1, v0};
    cdb_valid = cv; cdb_tag = ct; cdb_data = cd; unit_stall = stl;
    r[0] = r0; r[1] = r1; v[0] = v0; v[1] = v1;
    #1;
    st = model_stall(cls);
    chk(iss_stall === st, "R6", "iss_stall", 64'(iss_stall), 64'(st));
    // issue target from pre-edge occupancy (R2)
    tgt = -1;
    if (iv && !st) begin
      if (cls == 0) begin
        for (int s = 3; s >= 0; s--) if (!m_v[s]) tgt = s;
      end else if (cls <= 4) begin
        tgt = cls + 3;
      end
    end
    for (int s = 0; s < NRS; s++) rdyv[s] = m_v[s] && m_rdy[s][0] && m_rdy[s][1];
    for (int u = 0; u < NU; u++) e_dv[u] = 1'b0;
    for (int u = 1; u < NU; u++) if (rdyv[u+3] && !stl[u]) load_disp(u, u + 3);
    if (!stl[0]) begin
      found = 1'b0;
      for (int off = 0; off < 4; off++) begin
        int s;
        s = (m_ptr + off) % 4;
        if (!found && rdyv[s]) begin
          found = 1'b1;
          load_disp(0, s);
          m_ptr = (s + 1) % 4;
        end
      end
    end
    for (int s = 0; s < NRS; s++)
      for (int k = 0; k < NOPS; k++)
        if (m_v[s] && !m_rdy[s][k] && cv && m_val[s][k][3:0] == ct) begin
          m_rdy[s][k] = 1'b1;
          m_val[s][k] = cd;
        end
    if (tgt >= 0) begin
      m_v[tgt] = 1'b1; m_tag[tgt] = tg; m_opc[tgt] = opc;
      for (int k = 0; k < NOPS; k++) begin
        if (r[k]) begin
          m_rdy[tgt][k] = 1'b1; m_val[tgt][k] = v[k];
        end else if (cv && v[k][3:0] == ct) begin
          m_rdy[tgt][k] = 1'b1; m_val[tgt][k] = cd;
        end else begin
          m_rdy[tgt][k] = 1'b0; m_val[tgt][k] = v[k];
        end
      end
    end
    @(posedge clk);
    #1;
    for (int u = 0; u < NU; u++) begin
      string req;
      req = (u == 0) ? "R8" : "R2";
      chk(disp_valid[u] === e_dv[u], req, $sformatf("disp_valid[%0d]", u),
          64'(disp_valid[u]), 64'(e_dv[u]));
      if (e_dv[u]) begin
        chk(disp_tag[u*TW +: TW] === e_tag[u], "R3", $sformatf("tag[%0d]", u),
            64'(disp_tag[u*TW +: TW]), 64'(e_tag[u]));
        chk(disp_opc[u*OPW +: OPW] === e_opc[u], "R3", $sformatf("opc[%0d]", u),
            64'(disp_opc[u*OPW +: OPW]), 64'(e_opc[u]));
        for (int k = 0; k < NOPS; k++)
          chk(disp_ops[(u*NOPS+k)*DW +: DW] === e_ops[u][k], "R4",
              $sformatf("op[%0d][%0d]", u, k),
              64'(disp_ops[(u*NOPS+k)*DW +: DW]), 64'(e_ops[u][k]));
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [4:0] stl);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, stl);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    #1;
    chk(iss_stall === 1'b0, "R1", "iss_stall after reset", 64'(iss_stall), 0);
    chk(disp_valid === '0, "R1", "disp_valid after reset", 64'(disp_valid), 0);
    @(negedge clk);

    // R2 R3: one ready instruction per class
    for (int c = 1; c <= 4; c++)
      step(1, c, 4'(c), 8'(8'h10 + c), 1, 1, 32'(c * 100), 32'(c * 7), 0, 0, 0, 0);
    step(1, 0, 4'h9, 8'h77, 1, 1, 32'h1234, 32'h5678, 0, 0, 0, 0);
    idle(3, 0);

    // R6 R4: fill all integer stations with pending op0 tag 5, fifth one stalls
    for (int i = 0; i < 4; i++)
      step(1, 0, 4'(i), 8'(i), 0, 1, 32'h5, 32'(i), 0, 0, 0, 0);
    step(1, 0, 4'hf, 8'hff, 1, 1, 1, 1, 0, 0, 0, 0);
    // R6: class 1 station also held while unit 1 stalls
    step(1, 1, 4'h3, 8'h31, 1, 1, 3, 3, 0, 0, 0, 5'b00010);
    step(1, 1, 4'h4, 8'h41, 1, 1, 4, 4, 0, 0, 0, 5'b00010);
    idle(2, 5'b00010);
    // R8: broadcast fills every integer station while unit 0 stalls; pointer holds
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 4'h5, 32'hcafe_0005, 5'b00001);
    idle(2, 5'b00001);
    idle(6, 0);

    // R5: same-cycle broadcast bypass into an issuing instruction
    step(1, 2, 4'h6, 8'h62, 0, 1, 32'h2, 32'h22, 1, 4'h2, 32'hbeef_0002, 0);
    idle(3, 0);

    // R9: reserved class codes load nothing
    step(1, 5, 4'h1, 8'h51, 1, 1, 9, 9, 0, 0, 0, 0);
    step(1, 7, 4'h2, 8'h71, 1, 1, 9, 9, 0, 0, 0, 0);
    idle(3, 0);

    // random phase covering R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 4000; i++) begin
      bit r0, r1;
      r0 = ($urandom_range(0, 2) != 0);
      r1 = ($urandom_range(0, 2) != 0);
      step($urandom_range(0, 3) != 0, int'($urandom_range(0, 6)),
           4'($urandom), 8'($urandom),
           r0, r1,
           r0 ? $urandom : 32'($urandom_range(0, 3)),
           r1 ? $urandom : 32'($urandom_range(0, 3)),
           $urandom_range(0, 1) == 1, 4'($urandom_range(0, 3)), $urandom,
           5'($urandom & $urandom));
    end
    // drain: broadcast all small tags, no stalls
    for (int t = 0; t < 6; t++)
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 4'(t), 32'(t), 0);
    idle(6, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule